// File: doc/BRIEF.md
# Pipelined Synchronous SRAM with Late Write and Burst Counter

This block is a single-port synchronous static memory. Reads and writes can be mixed freely on consecutive clocks without idle cycles on the data bus. Every command input is captured on the rising clock edge. Read data leaves through an output register. Write data is taken two edges after its command, so a write's data occupies the same bus slot that a read issued in the same cycle would have used. The bidirectional data bus is modelled as a data-in vector, a data-out vector and a drive-enable.

A load cycle starts a transaction at the presented address. Advance cycles then step a 2-bit counter through the other three words of an aligned group of four. The order is either linear (increment modulo 4) or interleaved (start XOR count). Three chip selects support depth expansion. Per-lane write enables give partial-word writes. A sleep input stops the block from accepting commands while keeping all of its state. An output-enable input gates the bus drivers without waiting for a clock.

Top module: `pipe_sram`

## Requirements
- R1: A load cycle (advance=0) starts a transaction only when selAN=0, selB=1, selCN=0 and sleep=0. Any other load cycle is a deselect: it issues nothing and ends any burst.
- R2: For a read issued at edge N, dOut holds the addressed word from edge N+1 until edge N+2. During that window dOe=1 when oeN=0 and sleep=0. In a slot that carries no read, dOe=0.
- R3: For a write issued at edge N, the memory takes dIn at edge N+2, and dOe stays 0 throughout that data slot.
- R4: On a write, lane i (dIn bits 8i+7..8i) is updated only when laneWrN[i]=0 in the cycle the command or advance was issued. The other lanes keep their contents.
- R5: Reads and writes may be issued on every consecutive clock in any mix, with no idle cycle between them.
- R6: A read issued one edge after a write to the same address returns the lanes being written from that write's data, and the remaining lanes from memory.
- R7: With linearOrder=1, the k-th advance after a load (k = 1, 2, 3, then wrapping) uses address bits [1:0] = (start + k) mod 4. The upper bits come from the start address.
- R8: With linearOrder=0, the k-th advance uses address bits [1:0] = start[1:0] XOR (k mod 4).
- R9: An advance cycle repeats the read or write type of its load and ignores the chip selects. After reset or a deselect, an advance issues nothing.
- R10: While sleep=1, no load or advance is accepted. A write already issued still takes its data and completes. The burst position is kept, and dOe=0.
- R11: oeN acts without a clock edge: dOe drops while oeN=1 and returns when it goes low within the same cycle.
- R12: During and after reset, dOe=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| addr | input | ADDR_W | Word address for load cycles |
| selAN | input | 1 | Chip select, active low |
| selB | input | 1 | Chip select, active high |
| selCN | input | 1 | Chip select, active low |
| wrN | input | 1 | 0 = write, 1 = read on load cycles |
| laneWrN | input | LANES | Per-lane write enables, active low |
| advance | input | 1 | 1 = continue burst, 0 = load |
| linearOrder | input | 1 | 1 = linear burst order, 0 = interleaved |
| sleep | input | 1 | Power-down request, active high |
| oeN | input | 1 | Asynchronous output enable, active low |
| dIn | input | LANES*LANE_W | Bus data into the memory |
| dOut | output | LANES*LANE_W | Bus data out of the memory |
| dOe | output | 1 | Bus drive enable |

## Verification
The case of interest is a read that lands in the same cycle as the commit of an older write to the same word. The read is issued one edge after a half-lane write to that address. The bench then expects a word whose written lanes come from the write's data and whose other lanes keep their old value. A later plain read of the same word confirms that only those lanes were stored. Sleep and output-enable are also toggled inside a live read slot, and the bench judges dOe immediately, before the next edge.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;

  // Control-to-datapath strobes
  typedef struct packed {
    logic outLoad;  // load output register from the read word
    logic wrEn;     // commit a pending write this edge
  } sram_strobe_t;

  // Low two address bits of the k-th word in a burst
  function automatic logic [1:0] burstLow(input logic [1:0] start,
                                          input logic [1:0] k,
                                          input logic       linear);
    return linear ? 2'(start + k) : (start ^ k);
  endfunction

endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned LANES  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              wrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              advance,
  input  logic              linearOrder,
  input  logic              sleep,
  output sram_strobe_t      stb,
  output logic [ADDR_W-1:0] rdAddr,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [LANES-1:0]  wrLanes,
  output logic [LANES-1:0]  fwdLanes,
  output logic              issueRd,
  output logic              issueWr
);

  logic              burstActive, burstWrite;
  logic [ADDR_W-1:0] baseAddr;
  logic [1:0]        burstCnt, nextCnt;
  logic              loadSel, advGo, issueValid, issueWrite;
  logic [ADDR_W-1:0] issueAddr;

  logic              s1Valid, s1Write;
  logic [ADDR_W-1:0] s1Addr;
  logic [LANES-1:0]  s1Lanes;
  logic              s2Valid;
  logic [ADDR_W-1:0] s2Addr;
  logic [LANES-1:0]  s2Lanes;

  always_comb begin
    loadSel    = !advance && !selAN && selB && !selCN && !sleep;
    advGo      = advance && burstActive && !sleep;
    nextCnt    = burstCnt + 2'd1;
    issueAddr  = loadSel ? addr
                         : {baseAddr[ADDR_W-1:2], burstLow(baseAddr[1:0], nextCnt, linearOrder)};
    issueValid = loadSel || advGo;
    issueWrite = loadSel ? !wrN : burstWrite;
  end

  assign issueRd = issueValid && !issueWrite;
  assign issueWr = issueValid && issueWrite;

  // Burst state: untouched while sleeping
  always_ff @(posedge clk) begin
    if (!rstN) begin
      burstActive <= 1'b0;
      burstWrite  <= 1'b0;
      baseAddr    <= '0;
      burstCnt    <= '0;
    end else if (!sleep) begin
      if (!advance) begin
        burstActive <= loadSel;
        burstWrite  <= !wrN;
        baseAddr    <= addr;
        burstCnt    <= '0;
      end else if (advGo) begin
        burstCnt <= nextCnt;
      end
    end
  end

  // Stage 1: issued command; stage 2: write waiting for its data
  always_ff @(posedge clk) begin
    if (!rstN) begin
      s1Valid <= 1'b0;
      s1Write <= 1'b0;
      s1Addr  <= '0;
      s1Lanes <= '0;
      s2Valid <= 1'b0;
      s2Addr  <= '0;
      s2Lanes <= '0;
    end else begin
      s1Valid <= issueValid;
      s1Write <= issueWrite;
      s1Addr  <= issueAddr;
      s1Lanes <= ~laneWrN;
      s2Valid <= s1Valid && s1Write;
      s2Addr  <= s1Addr;
      s2Lanes <= s1Lanes;
    end
  end

  assign stb.outLoad = s1Valid && !s1Write;
  assign stb.wrEn    = s2Valid;
  assign rdAddr      = s1Addr;
  assign wrAddr      = s2Addr;
  assign wrLanes     = s2Lanes;
  assign fwdLanes    = (s2Valid && (s2Addr == s1Addr)) ? s2Lanes : '0;

endmodule

// File: rtl/pipe_sram_dp.sv
module pipe_sram_dp
  import pipe_sram_pkg::*;
#(
  parameter  int unsigned ADDR_W = 6,
  parameter  int unsigned LANES  = 4,
  parameter  int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W,
  localparam int unsigned DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  sram_strobe_t      stb,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LANES-1:0]  wrLanes,
  input  logic [LANES-1:0]  fwdLanes,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              outValid
);

  logic [DATA_W-1:0] rdWord;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] laneMem [DEPTH];

    always_ff @(posedge clk) begin
      if (stb.wrEn && wrLanes[g]) laneMem[wrAddr] <= dIn[g*LANE_W +: LANE_W];
    end

    // Newest value wins: a lane being committed now is taken from the bus
    assign rdWord[g*LANE_W +: LANE_W] = fwdLanes[g] ? dIn[g*LANE_W +: LANE_W]
                                                    : laneMem[rdAddr];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dOut     <= '0;
      outValid <= 1'b0;
    end else begin
      outValid <= stb.outLoad;
      if (stb.outLoad) dOut <= rdWord;
    end
  end

endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter  int unsigned ADDR_W = 6,
  parameter  int unsigned LANES  = 4,
  parameter  int unsigned LANE_W = 8,
  localparam int unsigned DATA_W = LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selAN,
  input  logic              selB,
  input  logic              selCN,
  input  logic              wrN,
  input  logic [LANES-1:0]  laneWrN,
  input  logic              advance,
  input  logic              linearOrder,
  input  logic              sleep,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dIn,
  output logic [DATA_W-1:0] dOut,
  output logic              dOe
);

  sram_strobe_t      stb;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [LANES-1:0]  wrLanes, fwdLanes;
  logic              issueRd, issueWr, outValid, commitWr;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .selAN(selAN), .selB(selB), .selCN(selCN),
    .wrN(wrN), .laneWrN(laneWrN), .advance(advance), .linearOrder(linearOrder),
    .sleep(sleep), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr), .wrLanes(wrLanes),
    .fwdLanes(fwdLanes), .issueRd(issueRd), .issueWr(issueWr)
  );

  pipe_sram_dp #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .rdAddr(rdAddr), .wrAddr(wrAddr),
    .wrLanes(wrLanes), .fwdLanes(fwdLanes), .dIn(dIn), .dOut(dOut), .outValid(outValid)
  );

  assign commitWr = stb.wrEn;
  assign dOe      = outValid && !oeN && !sleep;

endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk (
  input logic clk,
  input logic rstN,
  input logic oeN,
  input logic sleep,
  input logic dOe,
  input logic issueRd,
  input logic issueWr,
  input logic commitWr
);

  p_read_slot_r2: assert property (@(posedge clk) disable iff (!rstN)
    issueRd |=> ##1 (oeN || sleep || dOe));

  p_write_slot_r3: assert property (@(posedge clk) disable iff (!rstN)
    issueWr |=> ##1 !dOe);

  p_commit_follows_r3: assert property (@(posedge clk) disable iff (!rstN)
    issueWr |=> ##1 commitWr);

  p_commit_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    commitWr |-> $past(issueWr, 2));

  p_sleep_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dOe);

  p_sleep_no_issue_r10: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !(issueRd || issueWr));

  p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dOe);

endmodule

bind pipe_sram pipe_sram_chk chk_i (
  .clk(clk), .rstN(rstN), .oeN(oeN), .sleep(sleep), .dOe(dOe),
  .issueRd(issueRd), .issueWr(issueWr), .commitWr(commitWr)
);

// File: tb/pipe_sram_tb_top.sv
module pipe_sram_tb_top;

  localparam int AW = 6;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rstN;
  logic [AW-1:0] addr;
  logic          selAN, selB, selCN, wrN, advance, linearOrder, sleep, oeN;
  logic [3:0]    laneWrN;
  logic [DW-1:0] dIn;
  logic [DW-1:0] dOut;
  logic          dOe;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  pipe_sram dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .selAN(selAN), .selB(selB), .selCN(selCN),
    .wrN(wrN), .laneWrN(laneWrN), .advance(advance), .linearOrder(linearOrder),
    .sleep(sleep), .oeN(oeN), .dIn(dIn), .dOut(dOut), .dOe(dOe)
  );

  typedef struct packed {
    logic          adv;
    logic          sel;
    logic          wr;
    logic [3:0]    lanes;
    logic [AW-1:0] a;
    logic [DW-1:0] din;
    logic          expOe;
    logic [DW-1:0] expData;
  } vec_t;

  // Row i drives a command and the write data of row i-2, then row i+2 checks its result
  localparam vec_t VEC [12] = '{
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd4, 32'h0,        1'b0, 32'h0},
    '{1'b0, 1'b1, 1'b1, 4'hF, 6'd5, 32'h0,        1'b0, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'h0, 6'd4, 32'h11111111, 1'b0, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'h0, 6'd5, 32'h22222222, 1'b0, 32'h0},
    '{1'b0, 1'b1, 1'b1, 4'h3, 6'd5, 32'h0,        1'b1, 32'h11111111},
    '{1'b0, 1'b1, 1'b0, 4'h0, 6'd5, 32'h0,        1'b1, 32'h22222222},
    '{1'b0, 1'b0, 1'b0, 4'h0, 6'd0, 32'hAAAABBBB, 1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b0, 4'h0, 6'd0, 32'h0,        1'b1, 32'h2222BBBB},  // R6 forward
    '{1'b0, 1'b0, 1'b0, 4'h0, 6'd0, 32'h0,        1'b0, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'h0, 6'd5, 32'h0,        1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b0, 4'h0, 6'd0, 32'h0,        1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b0, 4'h0, 6'd0, 32'h0,        1'b1, 32'h2222BBBB}   // R4 lanes
  };

  function automatic logic [DW-1:0] pat(input int a);
    return 32'hC0DE0000 | DW'(a);
  endfunction

  task automatic checkOut(input string req, input logic expOe, input logic [DW-1:0] expData);
    total++;
    if (dOe !== expOe || (expOe && dOut !== expData)) begin
      fails++;
      $display("FAIL %s: dOe=%0b dOut=%h expected dOe=%0b dOut=%h", req, dOe, dOut, expOe, expData);
    end
  endtask

  // selv = {selAN, selB, selCN}; 3'b010 selects the block
  task automatic put(input logic adv, input logic [2:0] selv, input logic wr,
                     input logic [3:0] lanes, input int a);
    advance = adv;
    {selAN, selB, selCN} = selv;
    wrN     = !wr;
    laneWrN = ~lanes;
    addr    = AW'(a);
  endtask

  task automatic idle();
    put(1'b0, 3'b101, 1'b0, 4'h0, 0);
    dIn = '0;
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; sleep = 1'b0; oeN = 1'b0; linearOrder = 1'b1;
    idle();
    repeat (3) tick();
    checkOut("R12 reset", 1'b0, '0);
    rstN = 1'b1;

    // R9: advance straight after reset issues nothing
    tick(); put(1'b1, 3'b010, 1'b0, 4'h0, 0);
    tick(); idle();
    tick(); checkOut("R9 advance after reset", 1'b0, '0);

    // Vector table: back-to-back mixes (R5), read slot (R2), forwarding (R6), lanes (R4)
    for (int i = 0; i < 12; i++) begin
      tick();
      checkOut(i == 7 ? "R6 forward" : (i == 11 ? "R4 lanes" :
               (VEC[i].expOe ? "R2 read slot" : "R3/R5 write slot")),
               VEC[i].expOe, VEC[i].expData);
      put(VEC[i].adv, VEC[i].sel ? 3'b010 : 3'b101, VEC[i].wr, VEC[i].lanes, VEC[i].a);
      dIn = VEC[i].din;
    end

    // R7: linear write burst from 9 covers 9,10,11,8
    tick(); idle();
    tick(); linearOrder = 1'b1; put(1'b0, 3'b010, 1'b1, 4'hF, 9);
    tick(); put(1'b1, 3'b101, 1'b0, 4'hF, 0); dIn = '0;
    tick(); put(1'b1, 3'b101, 1'b0, 4'hF, 0); dIn = pat(9);
    tick(); put(1'b1, 3'b101, 1'b0, 4'hF, 0); dIn = pat(10);
    tick(); idle(); dIn = pat(11);
    tick(); idle(); dIn = pat(8);
    tick(); idle(); put(1'b0, 3'b010, 1'b0, 4'h0, 8);
    tick(); put(1'b0, 3'b010, 1'b0, 4'h0, 9);
    tick(); checkOut("R7 linear word 8", 1'b1, pat(8));  put(1'b0, 3'b010, 1'b0, 4'h0, 10);
    tick(); checkOut("R7 linear word 9", 1'b1, pat(9));  put(1'b0, 3'b010, 1'b0, 4'h0, 11);
    tick(); checkOut("R7 linear word 10", 1'b1, pat(10)); idle();
    tick(); checkOut("R7 linear word 11", 1'b1, pat(11));

    // R8: interleaved read burst from 9 gives 9,8,11,10 then wraps to 9
    tick(); linearOrder = 1'b0; put(1'b0, 3'b010, 1'b0, 4'h0, 9);
    tick(); put(1'b1, 3'b101, 1'b0, 4'h0, 0);
    tick(); checkOut("R8 interleave 9", 1'b1, pat(9));   put(1'b1, 3'b101, 1'b0, 4'h0, 0);
    tick(); checkOut("R8 interleave 8", 1'b1, pat(8));   put(1'b1, 3'b101, 1'b0, 4'h0, 0);
    tick(); checkOut("R8 interleave 11", 1'b1, pat(11)); put(1'b1, 3'b101, 1'b0, 4'h0, 0);
    tick(); checkOut("R8 interleave 10", 1'b1, pat(10)); idle();
    tick(); checkOut("R8 wrap to 9", 1'b1, pat(9));

    // R9: advance after a deselect issues nothing
    tick(); put(1'b1, 3'b010, 1'b0, 4'h0, 0);
    tick(); idle();
    tick(); checkOut("R9 advance after deselect", 1'b0, '0);

    // R1: each single inactive select blocks the load; all active passes
    tick(); put(1'b0, 3'b110, 1'b0, 4'h0, 9);
    tick(); put(1'b0, 3'b000, 1'b0, 4'h0, 9);
    tick(); checkOut("R1 selAN high", 1'b0, '0); put(1'b0, 3'b011, 1'b0, 4'h0, 9);
    tick(); checkOut("R1 selB low", 1'b0, '0);   put(1'b0, 3'b010, 1'b0, 4'h0, 9);
    tick(); checkOut("R1 selCN high", 1'b0, '0); idle();
    tick(); checkOut("R1 all selected", 1'b1, pat(9));

    // R10: write in flight completes through sleep, new commands ignored
    tick(); put(1'b0, 3'b010, 1'b1, 4'hF, 20);
    tick(); sleep = 1'b1; put(1'b0, 3'b010, 1'b0, 4'h0, 20);
    tick(); put(1'b0, 3'b010, 1'b0, 4'h0, 20); dIn = pat(20);
    tick(); sleep = 1'b0; idle(); #1 checkOut("R10 read during sleep ignored", 1'b0, '0);
    tick(); put(1'b0, 3'b010, 1'b0, 4'h0, 20);
    tick(); idle();
    tick(); checkOut("R10 in-flight write kept", 1'b1, pat(20));

    // R10 / R11: sleep and oeN gate the drive inside a live read slot
    sleep = 1'b1; #1 checkOut("R10 sleep masks drive", 1'b0, '0);
    sleep = 1'b0; #1 checkOut("R10 drive returns", 1'b1, pat(20));
    oeN = 1'b1;   #1 checkOut("R11 oeN high", 1'b0, '0);
    oeN = 1'b0;   #1 checkOut("R11 oeN low again", 1'b1, pat(20));

    // R10: burst position held across sleep
    tick(); linearOrder = 1'b1; put(1'b0, 3'b010, 1'b0, 4'h0, 9);
    tick(); sleep = 1'b1; put(1'b1, 3'b101, 1'b0, 4'h0, 0);
    tick(); sleep = 1'b0; put(1'b1, 3'b101, 1'b0, 4'h0, 0);
    #1 checkOut("R10 burst start", 1'b1, pat(9));
    tick(); checkOut("R10 advance in sleep ignored", 1'b0, '0); idle();
    tick(); checkOut("R10 burst resumes at 10", 1'b1, pat(10));

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule